// File: doc/BRIEF.md
# Banked Memory Map Controller

This block sets how a 64 KB address space, split into four 16 KB quarters, is mapped onto memory. It holds an 8-bit write-only configuration register. A qualified I/O write to port 0x38 loads the register. The register value, together with the top two address lines and the memory-cycle qualifiers, drives the active-low chip selects for the on-board ROM, for two 32K×8 on-board SRAMs and for off-board memory.

The bottom quarter can show either ROM or RAM, and software can change it in either direction at any time. The third quarter is a window onto one of eight RAM banks. Bank 0 is on-board RAM, and any other bank is passed off-board through its own select and a bank number output. The same register also drives three more things: the interrupt-enable input of the on-board interrupt daisy chain, and two ROM bank lines that give four 16 KB ROM banks.

The register layout is:

| Bits | Meaning |
|------|---------|
| 0 | ROM disable |
| 3:1 | RAM window bank |
| 4 | Interrupt enable, 1 = enabled |
| 6:5 | ROM bank |
| 7 | Spare |

A debug port shows the register value so that it can be observed.

Top module: `bank_map_top`

## Requirements
- R1: An active-low asynchronous reset clears the register to 0x00 at once. After reset the debug output, the RAM bank, the ROM bank and the interrupt-enable output all read 0.
- R2: If the write strobe is high at a rising clock edge and the port address is 0x38, the register loads all eight data bits. The new value shows on the debug output right after that edge.
- R3: Two kinds of write leave the register unchanged: a strobe with any port address other than 0x38, and port 0x38 without the strobe.
- R4: The bottom quarter (A15..A14 = 00) selects ROM when bit 0 is 0, and RAM chip 0 when bit 0 is 1.
- R5: Quarter 01 always selects RAM chip 0. Quarter 11 always selects RAM chip 1.
- R6: Quarter 10 selects RAM chip 1 when bits 3:1 are 0. Otherwise it selects off-board memory. The RAM bank output always equals bits 3:1.
- R7: The interrupt-enable output equals bit 4.
- R8: The two ROM bank outputs equal bits 6:5.
- R9: A memory select is asserted only when the memory-request input is low and the refresh input is high. At most one select is low at any time. Select outputs are ordered ROM, RAM0, RAM1, off-board, and each is active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioWrStb | input | 1 | Qualified I/O write strobe |
| ioAddr | input | 8 | I/O port address |
| dataIn | input | 8 | Data bus |
| mreqN | input | 1 | Memory request, active low |
| rfshN | input | 1 | Refresh cycle, active low |
| addrHi | input | 2 | Address lines A15..A14 |
| romSelN | output | 1 | On-board ROM select, active low |
| ram0SelN | output | 1 | RAM chip 0 select (0x0000-0x7FFF), active low |
| ram1SelN | output | 1 | RAM chip 1 select (0x8000-0xFFFF), active low |
| extSelN | output | 1 | Off-board memory select, active low |
| ramBank | output | 3 | Window bank number |
| romBank | output | 2 | ROM bank lines |
| intEnOut | output | 1 | Interrupt chain enable |
| cfgDbg | output | 8 | Register value, for observation |

## Verification
A register load shows on the outputs one clock edge after the strobe is sampled. The bench therefore drives each write on a falling edge and checks the result on the next falling edge. The selects and the bank outputs are combinational from the register and the address and qualifier pins, so those checks are made a short delay after the inputs change, with no clock edge in between. Reset acts asynchronously and is checked while it is still held low.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int CFG_W = 8;
  localparam int ROM_DIS_BIT = 0;
  localparam int BANK_LSB = 1;
  localparam int BANK_W = 3;
  localparam int INT_EN_BIT = 4;
  localparam int ROMBANK_LSB = 5;
  localparam int ROMBANK_W = 2;

  typedef struct packed {
    logic cfgLoad;
  } ctrlStb_t;
endpackage

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] CFG_PORT = 8'h38
) (
  input  logic              ioWrStb,
  input  logic [PORT_W-1:0] ioAddr,
  output ctrlStb_t          stb
);
  always_comb begin
    stb.cfgLoad = ioWrStb && (ioAddr == CFG_PORT);
  end
endmodule

// File: rtl/bank_map_dp.sv
module bank_map_dp
  import bank_map_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [CFG_W-1:0]     dataIn,
  input  logic                 mreqN,
  input  logic                 rfshN,
  input  logic [1:0]           addrHi,
  output logic                 romSelN,
  output logic                 ram0SelN,
  output logic                 ram1SelN,
  output logic                 extSelN,
  output logic [BANK_W-1:0]    ramBank,
  output logic [ROMBANK_W-1:0] romBank,
  output logic                 intEnOut,
  output logic [CFG_W-1:0]     cfgDbg
);
  logic [CFG_W-1:0] cfgQ;
  logic memCycle;
  logic romDis;
  logic [3:0] quarterHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (stb.cfgLoad) cfgQ <= dataIn;
  end

  assign romDis   = cfgQ[ROM_DIS_BIT];
  assign ramBank  = cfgQ[BANK_LSB +: BANK_W];
  assign romBank  = cfgQ[ROMBANK_LSB +: ROMBANK_W];
  assign intEnOut = cfgQ[INT_EN_BIT];
  assign cfgDbg   = cfgQ;
  assign memCycle = !mreqN && rfshN;

  for (genvar q = 0; q < 4; q++) begin : g_quarter
    assign quarterHit[q] = memCycle && (addrHi == 2'(q));
  end

  always_comb begin
    romSelN  = !(quarterHit[0] && !romDis);
    ram0SelN = !((quarterHit[0] && romDis) || quarterHit[1]);
    ram1SelN = !((quarterHit[2] && (ramBank == '0)) || quarterHit[3]);
    extSelN  = !(quarterHit[2] && (ramBank != '0));
  end

  always_comb begin
    assert_one_sel_R9: assert ($countones({romSelN, ram0SelN, ram1SelN, extSelN}) >= 3);
  end

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mreqN || !rfshN) |-> (romSelN && ram0SelN && ram1SelN && extSelN));
  assert_rom_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !romSelN |-> (addrHi == 2'b00));
  assert_ext_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    !extSelN |-> (addrHi == 2'b10 && ramBank != 3'd0));
endmodule

// File: rtl/bank_map_top.sv
module bank_map_top
  import bank_map_pkg::*;
#(
  parameter logic [7:0] CFG_PORT = 8'h38
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioWrStb,
  input  logic [7:0] ioAddr,
  input  logic [7:0] dataIn,
  input  logic       mreqN,
  input  logic       rfshN,
  input  logic [1:0] addrHi,
  output logic       romSelN,
  output logic       ram0SelN,
  output logic       ram1SelN,
  output logic       extSelN,
  output logic [2:0] ramBank,
  output logic [1:0] romBank,
  output logic       intEnOut,
  output logic [7:0] cfgDbg
);
  ctrlStb_t stb;

  bank_map_ctrl #(.PORT_W(8), .CFG_PORT(CFG_PORT)) u_ctrl (
    .ioWrStb(ioWrStb), .ioAddr(ioAddr), .stb(stb)
  );

  bank_map_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .mreqN(mreqN), .rfshN(rfshN), .addrHi(addrHi),
    .romSelN(romSelN), .ram0SelN(ram0SelN), .ram1SelN(ram1SelN),
    .extSelN(extSelN), .ramBank(ramBank), .romBank(romBank),
    .intEnOut(intEnOut), .cfgDbg(cfgDbg)
  );

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrStb && ioAddr == CFG_PORT) |=> (cfgDbg == $past(dataIn)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWrStb && ioAddr == CFG_PORT) |=> $stable(cfgDbg));
endmodule

// File: tb/sim_bank_map_top.sv
module sim_bank_map_top;
  logic clk = 0;
  logic rstN = 0;
  logic ioWrStb = 0;
  logic [7:0] ioAddr = 0;
  logic [7:0] dataIn = 0;
  logic mreqN = 1;
  logic rfshN = 1;
  logic [1:0] addrHi = 0;
  logic romSelN, ram0SelN, ram1SelN, extSelN, intEnOut;
  logic [2:0] ramBank;
  logic [1:0] romBank;
  logic [7:0] cfgDbg;
  int nChk = 0;
  int nBad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bank_map_top u0 (
    .clk(clk), .rstN(rstN), .ioWrStb(ioWrStb), .ioAddr(ioAddr), .dataIn(dataIn),
    .mreqN(mreqN), .rfshN(rfshN), .addrHi(addrHi),
    .romSelN(romSelN), .ram0SelN(ram0SelN), .ram1SelN(ram1SelN), .extSelN(extSelN),
    .ramBank(ramBank), .romBank(romBank), .intEnOut(intEnOut), .cfgDbg(cfgDbg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expSel(input logic [7:0] c, input logic [1:0] q,
                                        input logic mr, input logic rf);
    if (mr || !rf) return 4'b1111;
    case (q)
      2'd0: return c[0] ? 4'b1011 : 4'b0111;
      2'd1: return 4'b1011;
      2'd2: return (c[3:1] == 3'd0) ? 4'b1101 : 4'b1110;
      default: return 4'b1101;
    endcase
  endfunction

  task automatic doWrite(input logic stbV, input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    ioWrStb = stbV; ioAddr = port; dataIn = d;
    @(negedge clk);
    ioWrStb = 0; dataIn = ~d;
  endtask

  task automatic sweepDecode(input logic [7:0] c);
    for (int k = 0; k < 16; k++) begin
      addrHi = k[1:0]; mreqN = k[2]; rfshN = k[3];
      #1;
      if (mreqN || !rfshN)
        chk("R9 idle", {romSelN, ram0SelN, ram1SelN, extSelN}, expSel(c, addrHi, mreqN, rfshN));
      else if (addrHi == 2'd0)
        chk("R4 low quarter", {romSelN, ram0SelN, ram1SelN, extSelN}, expSel(c, addrHi, mreqN, rfshN));
      else if (addrHi == 2'd2)
        chk("R6 window", {romSelN, ram0SelN, ram1SelN, extSelN}, expSel(c, addrHi, mreqN, rfshN));
      else
        chk("R5 fixed RAM", {romSelN, ram0SelN, ram1SelN, extSelN}, expSel(c, addrHi, mreqN, rfshN));
    end
    mreqN = 1;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nBad++;
        $display("FAIL watchdog: actual %0d expected <150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", cfgDbg, 8'h00);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset banks", {ramBank, romBank, intEnOut}, 6'd0);
    sweepDecode(8'h00);

    for (int v = 0; v < 256; v++) begin
      doWrite(1'b1, 8'h38, v[7:0]);
      chk("R2 load", cfgDbg, v[7:0]);
      chk("R6 bank out", ramBank, v[3:1]);
      chk("R7 int enable", intEnOut, v[4]);
      chk("R8 rom bank", romBank, v[6:5]);
      sweepDecode(v[7:0]);
    end

    doWrite(1'b1, 8'h38, 8'h01);
    chk("R4 rom off", cfgDbg, 8'h01);
    doWrite(1'b1, 8'h38, 8'h00);
    sweepDecode(8'h00);

    doWrite(1'b1, 8'h38, 8'h5A);
    for (int p = 0; p < 256; p++) begin
      if (p != 8'h38) begin
        doWrite(1'b1, p[7:0], 8'hA5 ^ p[7:0]);
        chk("R3 other port", cfgDbg, 8'h5A);
      end
    end
    doWrite(1'b0, 8'h38, 8'h33);
    chk("R3 no strobe", cfgDbg, 8'h5A);

    doWrite(1'b1, 8'h38, 8'hFF);
    #2 rstN = 0;
    #1 chk("R1 async reset", cfgDbg, 8'h00);
    chk("R1 async banks", {ramBank, romBank, intEnOut}, 6'd0);
    @(negedge clk) rstN = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule